// File: doc/BRIEF.md
# Programmable LED status indicator

This block drives one LED pin of a network controller from a set of internal event lines (link up, receive activity, transmit activity, collision and similar). A 32-bit control register selects which events take part; the selected events are ORed together, optionally held on by a pulse stretcher so short bursts stay visible, and then driven onto the pin either as an active-low open-drain signal or as a push-pull signal whose level follows the OR.

Writes to the control register take effect only while an external programming-enable input is high. A hard reset (asynchronous, active low) restores every writable field; a synchronous soft reset restores only the event selection and stretch enable, leaving polarity and the spare bits alone. A stop input leaves the register untouched. Bit 15 of the read value always reports the live, unstretched OR of the enabled events.

Top module: `led_status_ctl`

## Requirements
- R1: The LED is active when the OR of all enabled events is true; event line ev[k] is enabled by register bit k for k = 0..6 and event line ev[7] by register bit 8; any mix of enables may be set.
- R2: After hard reset the register reads 32'h0000_0081 while no event is active: only ev[0] (link) enabled, stretch enable (bit 7) set, polarity (bit 14) and spare bits 13:9 cleared.
- R3: A write (wr_en high at a rising clock edge) changes the register only when prog_en is high; with prog_en low all fields keep their values.
- R4: Read bit 15 equals the current unstretched OR of enabled events; writes to it have no effect and polarity does not change it.
- R5: With polarity (bit 14) 0, led_o is 0 and led_oe equals the active state (driver released when inactive).
- R6: With polarity 1, led_oe is always 1 and led_o equals the active state.
- R7: With stretch enable (bit 7) set, the active state stays on for exactly STRETCH clock edges after the OR falls, and every edge at which the OR is true reloads the count.
- R8: With stretch enable clear, the active state equals the unstretched OR in the same cycle.
- R9: Soft reset sets bits 8 and 6:0 back to their reset values, sets bit 7, and ends any stretch in progress; polarity and bits 13:9 keep their values.
- R10: When a permitted write and a soft reset coincide, soft reset decides bits 8:0 and the write decides bits 14:9.
- R11: Stop has no effect on any register field or on the LED.
- R12: Bits 31:16 read as zero and bits 13:9 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| srst | input | 1 | Soft reset, synchronous, active high |
| stop | input | 1 | Stop request |
| prog_en | input | 1 | Programming enable for the register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| ev | input | NEV | Event lines |
| led_o | output | 1 | LED pin level |
| led_oe | output | 1 | LED pin output enable |

## Verification
A permitted register write and a soft reset can land on the same clock edge, and they touch overlapping fields. The bench raises srst together with a write that sets every enable, polarity and all spare bits, then reads back: bits 8:0 must hold the reset pattern while bits 14:9 carry the written values. A second collision, an event rising during a running stretch, is judged by counting the edges until the LED goes inactive from the last reload.

// File: rtl/led_status_ctl.sv
`timescale 1ns/1ps
module led_status_ctl #(
  parameter int NEV     = 8,
  parameter int STRETCH = 65536
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            srst,
  input  logic            stop,
  input  logic            prog_en,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  input  logic [NEV-1:0]  ev,
  output logic            led_o,
  output logic            led_oe
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [NEV-1:0] EN_RST = NEV'(1);

  logic [NEV-1:0] en_q;
  logic           pse_q;
  logic           pol_q;
  logic [4:0]     spare_q;
  logic [CW-1:0]  cnt_q;
  logic           hit;
  logic           held;
  logic           act;
  logic           wr_ok;
  logic [NEV-1:0] en_wr;

  assign wr_ok = wr_en & prog_en;
  assign en_wr = {wr_data[8], wr_data[6:0]};
  assign hit   = |(ev & en_q);
  assign held  = hit | (cnt_q != '0);
  assign act   = pse_q ? held : hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= EN_RST;
      pse_q   <= 1'b1;
      pol_q   <= 1'b0;
      spare_q <= '0;
    end else begin
      if (srst) begin
        en_q  <= EN_RST;
        pse_q <= 1'b1;
      end else if (wr_ok) begin
        en_q  <= en_wr;
        pse_q <= wr_data[7];
      end
      if (wr_ok) begin
        pol_q   <= wr_data[14];
        spare_q <= wr_data[13:9];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (srst)       cnt_q <= '0;
    else if (hit)        cnt_q <= CW'(STRETCH);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign rd_data = {16'h0000, hit, pol_q, spare_q, en_q[7], pse_q, en_q[6:0]};
  assign led_o   = pol_q & act;
  assign led_oe  = pol_q | act;

  logic unused_stop;
  assign unused_stop = stop;
endmodule

module led_status_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        srst,
  input logic        prog_en,
  input logic [31:0] rd_data,
  input logic        led_o,
  input logic        led_oe
);
  logic active;
  assign active = rd_data[14] ? led_o : led_oe;

  // R3
  no_write_when_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_en && !srst) |=> $stable(rd_data[14:0] & 15'h7fff));
  // R4
  or_shows_on_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15] |-> active);
  // R5
  open_drain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[14] |-> !led_o);
  // R6
  push_pull_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[14] |-> led_oe);
  // R8
  no_stretch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |-> (active == rd_data[15]));
  // R9
  soft_reset_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (rd_data[8:0] == 9'h081));
  // R12
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:16] == 16'h0000);
endmodule

bind led_status_ctl led_status_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst), .prog_en(prog_en),
  .rd_data(rd_data), .led_o(led_o), .led_oe(led_oe)
);

// File: tb/led_status_ctl_tb.sv
`timescale 1ns/1ps
module led_status_ctl_tb;
  localparam int ST = 8;
  logic clk = 0, rst_n = 0, srst = 0, stop = 0, prog_en = 0, wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [7:0]  ev = 0;
  logic led_o, led_oe;
  int total = 0, bad = 0;

  led_status_ctl #(.NEV(8), .STRETCH(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .srst(srst), .stop(stop), .prog_en(prog_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ev(ev),
    .led_o(led_o), .led_oe(led_oe));

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic pe);
    @(negedge clk);
    wr_en = 1; wr_data = d; prog_en = pe;
    @(negedge clk);
    wr_en = 0; prog_en = 0;
    #1;
  endtask

  task automatic hard_reset();
    @(negedge clk); rst_n = 0; ev = 0;
    @(negedge clk); rst_n = 1; #1;
  endtask

  task automatic t_reset();
    hard_reset();
    check("R2 reset value", rd_data, 32'h0000_0081);
    check("R5 idle pin", {30'd0, led_o, led_oe}, 32'd0);
  endtask

  task automatic t_select();
    hard_reset();
    wr(32'h0000_0100 | 32'h4000, 1);
    ev = 8'h80; #1;
    check("R1 ev7 via bit8", {31'd0, led_o}, 32'd1);
    ev = 8'h01; #1;
    check("R1 ev0 disabled", {31'd0, led_o}, 32'd0);
    check("R4 or bit", {31'd0, rd_data[15]}, 32'd0);
    wr(32'h0000_4105, 1);
    ev = 8'h04; #1;
    check("R1 ev2 of mix", {31'd0, led_o}, 32'd1);
    ev = 8'h02; #1;
    check("R1 ev1 not enabled", {31'd0, led_o}, 32'd0);
    ev = 0;
  endtask

  task automatic t_protect();
    hard_reset();
    wr(32'h0000_7e7f, 0);
    check("R3 locked write ignored", rd_data, 32'h0000_0081);
    wr(32'h0000_3e00, 1);
    check("R12 spare readback", rd_data, 32'h0000_3e00);
    wr(32'hffff_8000, 1);
    check("R4 bit15 write no effect", rd_data, 32'h0000_0000);
  endtask

  task automatic t_polarity();
    hard_reset();
    wr(32'h0000_0001, 1);
    ev = 1; #1;
    check("R5 open drain active", {30'd0, led_o, led_oe}, 32'd1);
    check("R4 or bit pol0", {31'd0, rd_data[15]}, 32'd1);
    ev = 0; #1;
    check("R5 released", {30'd0, led_o, led_oe}, 32'd0);
    wr(32'h0000_4001, 1);
    ev = 1; #1;
    check("R6 push pull high", {30'd0, led_o, led_oe}, 32'd3);
    check("R4 or bit pol1", {31'd0, rd_data[15]}, 32'd1);
    ev = 0; #1;
    check("R6 push pull low", {30'd0, led_o, led_oe}, 32'd1);
  endtask

  task automatic t_stretch();
    int ok;
    hard_reset();
    wr(32'h0000_4081, 1);
    @(negedge clk); ev = 1;
    @(negedge clk); ev = 0; #1;
    check("R7 held at fall", {31'd0, led_o}, 32'd1);
    check("R4 unstretched or", {31'd0, rd_data[15]}, 32'd0);
    ok = 1;
    for (int i = 1; i < ST; i++) begin
      @(negedge clk); #1;
      if (led_o !== 1'b1) ok = 0;
    end
    check("R7 held full window", ok, 1);
    @(negedge clk); #1;
    check("R7 ends after STRETCH", {31'd0, led_o}, 32'd0);
    @(negedge clk); ev = 1;
    @(negedge clk); ev = 0;
    repeat (4) @(negedge clk);
    ev = 1;
    @(negedge clk); ev = 0;
    repeat (ST - 1) @(negedge clk);
    #1;
    check("R7 retrigger reload", {31'd0, led_o}, 32'd1);
    @(negedge clk); #1;
    check("R7 retrigger end", {31'd0, led_o}, 32'd0);
  endtask

  task automatic t_nostretch();
    hard_reset();
    wr(32'h0000_4001, 1);
    @(negedge clk); ev = 1;
    @(negedge clk); ev = 0; #1;
    check("R8 follows immediately", {31'd0, led_o}, 32'd0);
  endtask

  task automatic t_soft();
    hard_reset();
    wr(32'h0000_7a7e, 1);
    @(negedge clk); ev = 8'h01;
    wr(32'h0000_7a81, 1);
    @(negedge clk); ev = 0; srst = 1;
    @(negedge clk); srst = 0; #1;
    check("R9 soft reset fields", rd_data, 32'h0000_7a81);
    check("R9 stretch cut", {31'd0, led_o}, 32'd0);
  endtask

  task automatic t_collide();
    hard_reset();
    @(negedge clk);
    srst = 1; wr_en = 1; prog_en = 1; wr_data = 32'h0000_7fff;
    @(negedge clk);
    srst = 0; wr_en = 0; prog_en = 0; #1;
    check("R10 write plus soft reset", rd_data, 32'h0000_7e81);
  endtask

  task automatic t_stop();
    hard_reset();
    wr(32'h0000_5603, 1);
    @(negedge clk); stop = 1; ev = 8'h02;
    repeat (3) @(negedge clk);
    #1;
    check("R11 stop keeps fields", rd_data, 32'h0000_d603);
    check("R11 stop keeps led", {30'd0, led_o, led_oe}, 32'd3);
    stop = 0; ev = 0;
  endtask

  task automatic t_reserved();
    hard_reset();
    wr(32'hffff_7fff, 1);
    check("R12 upper zero", {16'd0, rd_data[31:16]}, 32'd0);
    hard_reset();
    check("R2 hard reset restores all", rd_data, 32'h0000_0081);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_select();
    t_protect();
    t_polarity();
    t_stretch();
    t_nostretch();
    t_soft();
    t_collide();
    t_stop();
    t_reserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule